// File: doc/BRIEF.md
# Masked Parallel Bit Deposit Unit

This execution unit spreads the low-order bits of a data word across the bit positions that a mask word selects. The lowest set mask bit receives data bit 0, the next set mask bit receives data bit 1, and so on. Every position whose mask bit is clear reads zero. Data bits beyond the number of set mask bits are dropped.

The operand is 32 or 64 bits wide. The width depends on the processor mode and on a width-select bit. The unit also decides whether the operation raises an invalid-opcode fault. An operation is issued with a one-cycle strobe. One cycle later the unit returns either a registered result with its valid strobe or a fault flag, never both.

Top module: `bit_deposit_unit`

## Requirements
- R1: For each result position m of the operand width, if mask bit m is 1, result bit m equals data bit k, where k is the number of set mask bits below position m.
- R2: Every result bit whose mask bit is 0 is zero.
- R3: The mode field is encoded 0 = real, 1 = virtual-8086, 2 = protected, 3 = 64-bit. In any mode other than 3 the operation is 32 bits wide, whatever the width-select bit says.
- R4: In mode 3 the operation is 64 bits wide when the width-select bit is 1, and 32 bits wide when it is 0.
- R5: When the vector-length bit is 1, the fault flag is raised and no result is produced.
- R6: In mode 0 or mode 1, the fault flag is raised and no result is produced.
- R7: Data bits at index equal to or above the population count of the effective mask never affect the result.
- R8: For a 32-bit operation, result bits 63:32 are zero and only bits 31:0 of the data and the mask are used.
- R9: An all-zero mask gives an all-zero result. An all-ones mask gives the data unchanged within the operand width.
- R10: An operation issued with valid_i high yields valid_o or fault_o exactly one cycle later. With no strobe, both outputs are low in the next cycle, and result_o is zero whenever valid_o is low.
- R11: While fault_o is high, valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| data_i | input | 64 | Source bits to deposit |
| mask_i | input | 64 | Position mask |
| mode_i | input | 2 | Processor mode (0 real, 1 virtual-8086, 2 protected, 3 64-bit) |
| wide_i | input | 1 | Width select, 1 requests 64 bits |
| vlen_i | input | 1 | Vector-length bit, must be 0 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Deposited result |
| fault_o | output | 1 | Invalid-opcode fault for the operation |

## Verification
The bench builds the unit with its default parameters: a 64-bit full width and a 32-bit narrow width. With these values the upper-half zeroing, the mode-dependent width choice and the truncation of data at the mask's population count can all be observed at the ports. The stimulus mixes directed masks (zero, all ones, single bits, alternating patterns, top-bit-only) with pseudo-random words across every mode, width and vector-length combination. Back-to-back and idle cycles are included, so the one-cycle latency and the idle-output behaviour are both exercised.

// File: rtl/bit_deposit_pkg.sv
package bit_deposit_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;
endpackage

// File: rtl/bit_deposit_decode.sv
module bit_deposit_decode
  import bit_deposit_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       wide_i,
  input  logic       vlen_i,
  output logic       fault_o,
  output logic       wide_op_o
);
  cpu_mode_e mode;
  assign mode = cpu_mode_e'(mode_i);

  always_comb begin
    fault_o   = vlen_i || (mode == MODE_REAL) || (mode == MODE_V86);
    wide_op_o = (mode == MODE_LONG) && wide_i;
  end
endmodule

// File: rtl/bit_deposit_scatter.sv
module bit_deposit_scatter #(
  parameter int W = 64
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] dst_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  // rank[b] = count of set mask bits strictly below position b
  logic [IW-1:0] rank [W];

  for (genvar b = 0; b < W; b++) begin : g_pos
    if (b == 0) begin : g_first
      assign rank[b] = '0;
    end else begin : g_rest
      assign rank[b] = rank[b-1] + IW'(mask_i[b-1]);
    end
    assign dst_o[b] = mask_i[b] & src_i[rank[b]];
  end
endmodule

// File: rtl/bit_deposit_unit.sv
module bit_deposit_unit #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [1:0]      mode_i,
  input  logic            wide_i,
  input  logic            vlen_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            fault_o
);
  localparam int UPPER_W = XLEN - NARROW_W;

  logic            fault_c, wide_op;
  logic [XLEN-1:0] mask_eff, res_c;

  bit_deposit_decode u_decode (
    .mode_i    (mode_i),
    .wide_i    (wide_i),
    .vlen_i    (vlen_i),
    .fault_o   (fault_c),
    .wide_op_o (wide_op)
  );

  // narrow op: clearing upper mask bits also keeps upper data unreachable
  if (UPPER_W > 0) begin : g_gate
    assign mask_eff = {mask_i[XLEN-1:NARROW_W] & {UPPER_W{wide_op}},
                       mask_i[NARROW_W-1:0]};
  end else begin : g_nogate
    assign mask_eff = mask_i;
  end

  bit_deposit_scatter #(.W(XLEN)) u_scatter (
    .src_i  (data_i),
    .mask_i (mask_eff),
    .dst_o  (res_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      fault_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i && !fault_c;
      fault_o  <= valid_i && fault_c;
      result_o <= (valid_i && !fault_c) ? res_c : '0;
    end
  end
endmodule

// File: rtl/bit_deposit_chk.sv
module bit_deposit_chk
  import bit_deposit_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] mask_i,
  input logic [1:0]      mode_i,
  input logic            wide_i,
  input logic            vlen_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            fault_o
);
  a_r11_fault_excludes_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !valid_o);

  a_r5_vlen_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i) |=> (fault_o && !valid_o));

  a_r6_legacy_mode_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == MODE_REAL || mode_i == MODE_V86)) |=> (fault_o && !valid_o));

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vlen_i && (mode_i == MODE_PROT || mode_i == MODE_LONG)) |=> valid_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !fault_o && result_o == '0));

  a_r2_clear_outside_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((result_o & ~$past(mask_i)) == '0));

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(mode_i == MODE_LONG && wide_i)) |=> (result_o[XLEN-1:NARROW_W] == '0));

  a_r7_popcount_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($countones(result_o) <= $countones($past(mask_i))));
endmodule

bind bit_deposit_unit bit_deposit_chk #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mask_i   (mask_i),
  .mode_i   (mode_i),
  .wide_i   (wide_i),
  .vlen_i   (vlen_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .fault_o  (fault_o)
);

// File: tb/bit_deposit_unit_tb_top.sv
`timescale 1ns/1ps
module bit_deposit_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] data_i = '0, mask_i = '0;
  logic [1:0]  mode_i = 2'd2;
  logic        wide_i = 1'b0, vlen_i = 1'b0;
  logic        valid_o, fault_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  logic        exp_v = 1'b0, exp_f = 1'b0;
  logic [63:0] exp_r = '0;
  string       exp_tag = "R10";
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  bit_deposit_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .mask_i(mask_i), .mode_i(mode_i), .wide_i(wide_i), .vlen_i(vlen_i),
    .valid_o(valid_o), .result_o(result_o), .fault_o(fault_o)
  );

  // behavioural model: walk mask upward, consume data bits in order
  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] m,
                                        input int width);
    logic [63:0] r = '0;
    int k = 0;
    for (int p = 0; p < width; p++) begin
      if (m[p]) begin
        r[p] = d[k];
        k++;
      end
    end
    return r;
  endfunction

  task automatic compare();
    n_chk++;
    if (valid_o !== exp_v || fault_o !== exp_f || result_o !== exp_r) begin
      n_fail++;
      $display("FAIL %s: got v=%0b f=%0b r=%h, expected v=%0b f=%0b r=%h",
               exp_tag, valid_o, fault_o, result_o, exp_v, exp_f, exp_r);
    end
  endtask

  // called at negedge: check previous op, then drive a new one
  task automatic step(input logic v, input logic [63:0] d, input logic [63:0] m,
                      input logic [1:0] md, input logic w, input logic vl, input string tag);
    int width;
    logic flt;
    compare();
    valid_i = v; data_i = d; mask_i = m; mode_i = md; wide_i = w; vlen_i = vl;
    flt   = vl || (md == 2'd0) || (md == 2'd1);
    width = (md == 2'd3 && w) ? 64 : 32;
    exp_v = v && !flt;
    exp_f = v && flt;
    exp_r = exp_v ? model(d, m, width) : '0;
    exp_tag = tag;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, m;
    repeat (3) @(negedge clk_i);
    compare();  // R10 reset state: outputs low
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1/R9 directed
    step(1, 64'h0123_4567_89AB_CDEF, 64'h0, 2'd3, 1, 0, "R9 zero mask");
    step(1, 64'h0123_4567_89AB_CDEF, '1, 2'd3, 1, 0, "R9 ones mask 64");
    step(1, 64'h0123_4567_89AB_CDEF, '1, 2'd2, 1, 0, "R3 ones mask prot");
    step(1, 64'h0000_0000_0000_000F, 64'h8000_0000_0000_0000, 2'd3, 1, 0, "R1 top bit");
    step(1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001, 2'd3, 1, 0, "R1 single low");
    step(1, 64'h0000_0000_0000_0005, 64'hAAAA_AAAA_AAAA_AAAA, 2'd3, 1, 0, "R2 alternating");
    step(1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_F0F0, 2'd3, 1, 0, "R7 discard high data");
    step(1, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_0000_0000_0003, 2'd3, 0, 0, "R4 narrow in long");
    step(1, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_0000_0000_0003, 2'd3, 1, 0, "R4 wide in long");
    step(1, 64'hDEAD_BEEF_FFFF_FFFF, 64'hFFFF_FFFF_8000_0001, 2'd2, 0, 0, "R8 upper ignored");
    step(1, 64'h1, 64'h1, 2'd0, 0, 0, "R6 real mode");
    step(1, 64'h1, 64'h1, 2'd1, 1, 0, "R6 v86 mode");
    step(1, 64'h1, 64'h1, 2'd3, 1, 1, "R5 vlen set");
    step(0, 64'h1, 64'h1, 2'd3, 1, 0, "R10 idle");
    step(1, 64'h3, 64'h3, 2'd3, 1, 0, "R11 back to back");
    step(1, 64'h3, 64'h3, 2'd2, 0, 1, "R11 fault after ok");
    // random sweep over modes, widths, vector-length
    for (int i = 0; i < 3000; i++) begin
      d = {$urandom(), $urandom()};
      m = {$urandom(), $urandom()};
      if (i % 5 == 1) m = m & {$urandom(), $urandom()};
      if (i % 7 == 3) m = ~m;
      step(($urandom() % 4) != 0, d, m, 2'($urandom()), 1'($urandom()),
           ($urandom() % 8) == 0, "R1 random");
    end
    step(0, '0, '0, 2'd2, 0, 0, "R10 drain");
    compare();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule